// File: doc/BRIEF.md
# Block and Masked Write Unit

This unit sits in front of the random-access port of a memory whose words are four bits wide. It works out which columns and which bits change on a write, and what the new data is. The column address is always widened to a group of adjacent columns whose first address has its low bits cleared. Each cycle the unit returns one data word and one per-bit enable word for every column in that group.

A normal write stores the data input into the single addressed column of the group. A block write stores the contents of an internal colour register into any subset of the group's columns. In that case the data input acts as the column-select mask, so one cycle can write up to sixteen bits. The unit also keeps a persistent bit mask. When a write asks for masking, bits cleared in that mask keep their old value. The old contents of the group are supplied on an input, and the unit merges old and new data bit by bit, as a read-modify-write would.

The colour register and the mask register each have their own load command. They hold their values until the next load or until reset. Every result is registered, so it appears one cycle after its command.

Top module: `vram_block_write_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `wr_valid_o`, `col_en_o` and `bit_en_o` are 0. Reset sets the colour register to 0 and the mask register to all ones, so a masked write issued before any mask load changes all four bits.
- R2: Command code 3 (load colour) copies `din_i` into the colour register and produces no write (`wr_valid_o` stays 0). The colour register keeps its value until the next load colour.
- R3: Command code 4 (load mask) copies `din_i` into the mask register and produces no write. The mask stays in force for every later masked write until the next load mask.
- R4: Command code 1 (normal write) outputs `wr_base_o` equal to `col_addr_i` with its two low bits cleared. It sets only bit `col_addr_i[1:0]` of `col_en_o`, and writes `din_i` into that column, at bits [4c+3:4c] of the data output.
- R5: Command code 2 (block write) outputs `col_en_o` equal to `din_i`, where bit c enables column base+c. Every enabled column receives the colour register value.
- R6: When `mask_en_i` is 1, the per-bit enables of each enabled column equal the mask register. A bit whose mask bit is 0 outputs its old value from `old_data_i`.
- R7: When `mask_en_i` is 0, all four bits of every enabled column are enabled, whatever value the mask register holds.
- R8: A column that is not enabled has all its `bit_en_o` bits at 0, and its `wr_data_o` equals its `old_data_i`.
- R9: Outputs are registered. `wr_valid_o` is 1 in the cycle after a write command (code 1 or 2) and 0 after any other command. Back-to-back writes give back-to-back results.
- R10: A block write with `din_i` = 4'b1111 and masking off enables all 16 bits of the group in one cycle.
- R11: Command codes 0, 5, 6 and 7 produce no write, and they leave the colour and mask registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 3 | Command: 0 idle, 1 normal write, 2 block write, 3 load colour, 4 load mask |
| mask_en_i | input | 1 | Apply the stored bit mask to this write |
| col_addr_i | input | 9 | Column address |
| din_i | input | 4 | Write data, column-select mask, or register load value |
| old_data_i | input | 16 | Current contents of the aligned column group, column c at bits [4c+3:4c] |
| wr_valid_o | output | 1 | A write result is present |
| wr_base_o | output | 9 | Aligned base column of the group |
| col_en_o | output | 4 | Per-column enables |
| bit_en_o | output | 16 | Per-bit enables, column c at bits [4c+3:4c] |
| wr_data_o | output | 16 | Merged write data, column c at bits [4c+3:4c] |

## Verification
On every cycle the assertions check the following properties. A valid result follows exactly the write commands. A normal write enables exactly one column. Unmasked writes enable whole columns. Every bit that is not enabled carries the old data seen one cycle earlier. The colour and mask registers change only on their own load commands. Other behaviours need the bench's scenarios to show them: the mask coming out of reset as all ones, the mask persisting across idle and undefined commands, the colour value landing in the columns a block write selects, and the exact aligned base address.

// File: rtl/bw_pkg.sv
package bw_pkg;
  localparam int CMD_W = 3;

  typedef enum logic [CMD_W-1:0] {
    CMD_IDLE     = 3'd0,
    CMD_WRITE    = 3'd1,
    CMD_BLOCK    = 3'd2,
    CMD_LD_COLOR = 3'd3,
    CMD_LD_MASK  = 3'd4
  } cmd_e;

  function automatic logic cmd_is_write(input logic [CMD_W-1:0] c);
    return (c == CMD_WRITE) || (c == CMD_BLOCK);
  endfunction
endpackage

// File: rtl/bw_persist_regs.sv
module bw_persist_regs #(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_color,
  input  logic              load_mask,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] color_q,
  output logic [DATA_W-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      color_q <= '0;
      mask_q  <= '1;
    end else begin
      if (load_color) color_q <= din;
      if (load_mask)  mask_q  <= din;
    end
  end

  // R2: the colour register takes the load value
  assert_color_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_color |=> (color_q == $past(din)));
  // R2, R11: the colour register holds without a load
  assert_color_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_color |=> $stable(color_q));
  // R3, R11: the mask persists without a load
  assert_mask_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !load_mask |=> $stable(mask_q));
endmodule

// File: rtl/bw_col_select.sv
module bw_col_select
  import bw_pkg::*;
#(
  parameter int LANES = 4,
  localparam int SEL_W = $clog2(LANES)
) (
  input  logic [CMD_W-1:0] cmd,
  input  logic [SEL_W-1:0] lane_sel,
  input  logic [LANES-1:0] din,
  output logic             is_wr,
  output logic             is_block,
  output logic [LANES-1:0] col_en
);
  function automatic logic [LANES-1:0] lane_onehot(input logic [SEL_W-1:0] s);
    logic [LANES-1:0] r;
    r = '0;
    r[s] = 1'b1;
    return r;
  endfunction

  always_comb begin
    is_wr    = cmd_is_write(cmd);
    is_block = (cmd == CMD_BLOCK);
    if (cmd == CMD_WRITE)      col_en = lane_onehot(lane_sel);
    else if (cmd == CMD_BLOCK) col_en = din;
    else                       col_en = '0;
  end
endmodule

// File: rtl/bw_lane.sv
module bw_lane #(
  parameter int DATA_W = 4
) (
  input  logic              lane_en,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] old,
  input  logic [DATA_W-1:0] eff_mask,
  output logic [DATA_W-1:0] bit_en,
  output logic [DATA_W-1:0] data
);
  function automatic logic [DATA_W-1:0] merge_bits(
    input logic [DATA_W-1:0] prev, input logic [DATA_W-1:0] nxt,
    input logic [DATA_W-1:0] sel);
    return (nxt & sel) | (prev & ~sel);
  endfunction

  always_comb begin
    bit_en = lane_en ? eff_mask : '0;
    data   = merge_bits(old, src, bit_en);
  end
endmodule

// File: rtl/vram_block_write_unit.sv
module vram_block_write_unit
  import bw_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter int ADDR_W = 9
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [CMD_W-1:0]           cmd_i,
  input  logic                       mask_en_i,
  input  logic [ADDR_W-1:0]          col_addr_i,
  input  logic [DATA_W-1:0]          din_i,
  input  logic [DATA_W*DATA_W-1:0]   old_data_i,
  output logic                       wr_valid_o,
  output logic [ADDR_W-1:0]          wr_base_o,
  output logic [DATA_W-1:0]          col_en_o,
  output logic [DATA_W*DATA_W-1:0]   bit_en_o,
  output logic [DATA_W*DATA_W-1:0]   wr_data_o
);
  localparam int LANES = DATA_W;
  localparam int SEL_W = $clog2(LANES);
  localparam int GRP_W = LANES * DATA_W;

  function automatic logic [ADDR_W-1:0] align_base(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] r;
    r = a;
    r[SEL_W-1:0] = '0;
    return r;
  endfunction

  function automatic logic [GRP_W-1:0] spread_cols(input logic [LANES-1:0] ce);
    logic [GRP_W-1:0] r;
    for (int l = 0; l < LANES; l++) r[l*DATA_W +: DATA_W] = {DATA_W{ce[l]}};
    return r;
  endfunction

  logic              load_color_w, load_mask_w;
  logic              is_wr_w, is_block_w;
  logic [LANES-1:0]  col_en_w;
  logic [DATA_W-1:0] color_w, mask_w, eff_mask_w, src_w;
  logic [GRP_W-1:0]  bit_en_w, data_w;

  assign load_color_w = (cmd_i == CMD_LD_COLOR);
  assign load_mask_w  = (cmd_i == CMD_LD_MASK);

  bw_persist_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .load_color(load_color_w), .load_mask(load_mask_w),
    .din(din_i), .color_q(color_w), .mask_q(mask_w));

  bw_col_select #(.LANES(LANES)) u_sel (
    .cmd(cmd_i), .lane_sel(col_addr_i[SEL_W-1:0]), .din(din_i),
    .is_wr(is_wr_w), .is_block(is_block_w), .col_en(col_en_w));

  assign eff_mask_w = mask_en_i ? mask_w : '1;
  assign src_w      = is_block_w ? color_w : din_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bw_lane #(.DATA_W(DATA_W)) u_lane (
      .lane_en(col_en_w[g]), .src(src_w),
      .old(old_data_i[g*DATA_W +: DATA_W]), .eff_mask(eff_mask_w),
      .bit_en(bit_en_w[g*DATA_W +: DATA_W]), .data(data_w[g*DATA_W +: DATA_W]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid_o <= 1'b0;
      wr_base_o  <= '0;
      col_en_o   <= '0;
      bit_en_o   <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_valid_o <= is_wr_w;
      wr_base_o  <= align_base(col_addr_i);
      col_en_o   <= col_en_w;
      bit_en_o   <= bit_en_w;
      wr_data_o  <= data_w;
    end
  end

  // R9: a result follows exactly the write commands
  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (wr_valid_o == cmd_is_write($past(cmd_i))));
  // R4: a normal write enables one column
  assert_single_column_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cmd_i) == CMD_WRITE) |-> $onehot(col_en_o));
  // R7: unmasked writes enable whole columns
  assert_unmasked_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(mask_en_i)) |-> (bit_en_o == spread_cols(col_en_o)));
  // R6, R8: bits not enabled carry the old data
  assert_keep_old_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((wr_data_o & ~bit_en_o) == ($past(old_data_i) & ~bit_en_o)));
endmodule

// File: tb/vram_block_write_unit_test.sv
module vram_block_write_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cmd_i = 3'd0;
  logic        mask_en_i = 1'b0;
  logic [8:0]  col_addr_i = '0;
  logic [3:0]  din_i = '0;
  logic [15:0] old_data_i = '0;
  logic        wr_valid_o;
  logic [8:0]  wr_base_o;
  logic [3:0]  col_en_o;
  logic [15:0] bit_en_o, wr_data_o;

  always #5 clk = ~clk;

  vram_block_write_unit uut (.*);

  typedef struct {
    logic        valid;
    logic [8:0]  base;
    logic [3:0]  col;
    logic [15:0] ben;
    logic [15:0] data;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  logic [3:0] sh_color = 4'h0, sh_mask = 4'hF;

  task automatic drive(input logic [2:0] c, input logic m, input logic [8:0] a,
                       input logic [3:0] d, input logic [15:0] old, input string tag);
    exp_t e;
    @(negedge clk);
    cmd_i = c; mask_en_i = m; col_addr_i = a; din_i = d; old_data_i = old;
    e.tag = tag; e.valid = (c == 3'd1 || c == 3'd2);
    e.base = {a[8:2], 2'b00};
    e.col = '0; e.ben = '0; e.data = '0;
    if (e.valid) begin
      for (int l = 0; l < 4; l++) begin
        e.col[l] = (c == 3'd1) ? (a[1:0] == l[1:0]) : d[l];
        for (int b = 0; b < 4; b++) begin
          logic on;
          on = e.col[l] && (!m || sh_mask[b]);
          e.ben[l*4+b]  = on;
          e.data[l*4+b] = on ? ((c == 3'd2) ? sh_color[b] : d[b]) : old[l*4+b];
        end
      end
    end
    if (c == 3'd3) sh_color = d;
    if (c == 3'd4) sh_mask = d;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (wr_valid_o !== e.valid ||
          (e.valid && (wr_base_o !== e.base || col_en_o !== e.col ||
                       bit_en_o !== e.ben || wr_data_o !== e.data))) begin
        fails++;
        $display("FAIL %s: got v=%b base=%h col=%b ben=%h data=%h exp v=%b base=%h col=%b ben=%h data=%h",
                 e.tag, wr_valid_o, wr_base_o, col_en_o, bit_en_o, wr_data_o,
                 e.valid, e.base, e.col, e.ben, e.data);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    checks++;
    if (wr_valid_o !== 1'b0 || col_en_o !== 4'h0 || bit_en_o !== 16'h0) begin
      fails++;
      $display("FAIL R1: got v=%b col=%b ben=%h expected all zero", wr_valid_o, col_en_o, bit_en_o);
    end
    // R1: masked write before any mask load writes every bit
    drive(3'd1, 1'b1, 9'h005, 4'hA, 16'h5555, "R1");
    // R4: normal writes at each lane
    drive(3'd1, 1'b0, 9'h010, 4'h3, 16'hFFFF, "R4");
    drive(3'd1, 1'b0, 9'h0F7, 4'hC, 16'h1234, "R4");
    drive(3'd1, 1'b0, 9'h1FE, 4'h9, 16'h0000, "R4");
    // R2: load colour, no write
    drive(3'd3, 1'b0, 9'h000, 4'hC, 16'h0000, "R2");
    // R5: block write of colour into columns 1 and 3
    drive(3'd2, 1'b0, 9'h043, 4'b1010, 16'h3C3C, "R5");
    // R10: full sixteen-bit block write
    drive(3'd2, 1'b0, 9'h100, 4'hF, 16'h0000, "R10");
    // R3: load mask, no write
    drive(3'd4, 1'b0, 9'h000, 4'b0110, 16'h0000, "R3");
    // R6: masked normal and block writes
    drive(3'd1, 1'b1, 9'h002, 4'hF, 16'h0000, "R6");
    drive(3'd2, 1'b1, 9'h020, 4'b0111, 16'hAAAA, "R6");
    // R7: unmasked write ignores stored mask
    drive(3'd1, 1'b0, 9'h003, 4'h5, 16'hFFFF, "R7");
    // R8: block write with no columns selected
    drive(3'd2, 1'b1, 9'h080, 4'h0, 16'hBEEF, "R8");
    // R11: undefined and idle codes
    drive(3'd5, 1'b0, 9'h000, 4'h1, 16'h0000, "R11");
    drive(3'd6, 1'b0, 9'h000, 4'h2, 16'h0000, "R11");
    drive(3'd7, 1'b1, 9'h000, 4'h3, 16'h0000, "R11");
    drive(3'd0, 1'b0, 9'h000, 4'h4, 16'h0000, "R11");
    // R3, R11: mask and colour persist across other commands
    drive(3'd2, 1'b1, 9'h1F1, 4'hF, 16'h0F0F, "R3");
    drive(3'd3, 1'b0, 9'h000, 4'h5, 16'h0000, "R2");
    // R9: back-to-back writes
    drive(3'd2, 1'b0, 9'h0AB, 4'b1001, 16'h1111, "R9");
    drive(3'd1, 1'b1, 9'h0AD, 4'hE, 16'h2222, "R9");
    drive(3'd1, 1'b0, 9'h0AE, 4'h7, 16'h3333, "R9");
    drive(3'd4, 1'b0, 9'h000, 4'hF, 16'h0000, "R3");
    drive(3'd2, 1'b1, 9'h004, 4'b1100, 16'h0000, "R5");
    drive(3'd0, 1'b0, 9'h000, 4'h0, 16'h0000, "R9");
    repeat (3) @(posedge clk);
    #2;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule